// File: doc/BRIEF.md
# Diagnostic Threshold Monitor

This block watches five live 16-bit diagnostic readings from a transceiver: module temperature, supply voltage, laser bias current, transmit optical power and receive optical power. Each reading is checked against four programmable limits: a high alarm, a low alarm, a high warning and a low warning. The result is a bank of twenty sticky-between-samples flag bits and one summary alarm line.

Limits are loaded one byte at a time through a small write port that uses the byte offsets of the diagnostic page. Each limit is a big-endian byte pair. The upper byte is parked in a holding register and the limit changes only when its lower byte arrives, so a compare never sees a half-updated limit. Measurements arrive together as one 80-bit word qualified by a valid strobe. Temperature is compared as a signed value in 1/256 degree steps. Voltage (100 µV steps), bias (2 µA steps) and optical power (0.1 µW steps) are compared as unsigned values. Calibration and the host bus are handled elsewhere.

Top module: `dmon_thr_monitor`

## Requirements
- R1: After reset every limit is zero, all twenty flags are 0 and the summary alarm is 0. A sample of all readings equal to 0x0001 then sets every high flag and no low flag.
- R2: Limit slot s = q*4 + k occupies byte offset 2s (upper byte) and 2s+1 (lower byte). The quantity q is 0 temperature, 1 voltage, 2 bias, 3 transmit power and 4 receive power. The kind k is 0 high alarm, 1 low alarm, 2 high warning and 3 low warning.
- R3: A write to an even offset only stores a pending upper byte. The 16-bit limit of that slot takes the value {pending byte, written byte} on the clock edge of a write to the matching odd offset, and not before.
- R4: A write to an odd offset whose slot does not match the pending slot, or that has no pending byte, leaves all limits unchanged. Any in-range odd write discards the pending byte. Writes to offsets 40 and above are ignored and leave the pending byte intact.
- R5: Flags are re-evaluated on each clock edge where measValid is 1. They appear on the outputs after that edge and hold their value while measValid is 0, whatever the reading inputs do.
- R6: A high flag (k = 0 or 2) is 1 when the reading is strictly greater than its limit. A low flag (k = 1 or 3) is 1 when the reading is strictly less than its limit. Equality sets neither.
- R7: The temperature reading and its limits compare as signed two's complement. The other four quantities compare as unsigned.
- R8: The flag for slot s is flags[s]. The reading for quantity q is measData[16q+15:16q].
- R9: anyAlarm is 1 exactly when at least one high-alarm or low-alarm flag (k = 0 or 1) is 1. Warning flags have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Limit byte write enable |
| cfgAddr | input | 8 | Byte offset of the limit write |
| cfgData | input | 8 | Limit byte value |
| measValid | input | 1 | Sample strobe for measData |
| measData | input | 80 | Five packed 16-bit readings, temperature in the lowest slice |
| flags | output | 20 | Limit violation flags, bit s for slot s |
| anyAlarm | output | 1 | OR of the ten alarm flags |

## Verification
A vector table is applied, with the expected flags computed from a limit model in the bench. It covers nominal readings, readings beyond every high limit and below every low limit, and readings exactly equal to limits, which separates strict from inclusive compares. A negative temperature whose unsigned pattern is large tells signed from unsigned compare. A warning-only sample shows that warnings are kept out of the summary alarm. Directed writes cover the following cases: an upper byte alone, a lower byte for the wrong slot, a lower byte with nothing pending, and out-of-range offsets between a byte pair. Each case is judged by how a later sample is flagged. Changing the readings with the strobe low shows that the flags hold.

// File: rtl/dmon_pkg.sv
package dmon_pkg;
  localparam int QTY_N     = 5;
  localparam int KIND_N    = 4;
  localparam int VAL_W     = 16;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 8;
  localparam int THR_N     = QTY_N * KIND_N;
  localparam int SLOT_W    = $clog2(THR_N);
  localparam int MAP_BYTES = THR_N * 2;
  localparam int MEAS_W    = QTY_N * VAL_W;

  typedef struct packed {
    logic              sample;
    logic              commit;
    logic [SLOT_W-1:0] slot;
    logic [VAL_W-1:0]  value;
  } thr_strobe_t;
endpackage

// File: rtl/dmon_ctrl.sv
module dmon_ctrl
  import dmon_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWrEn,
  input  logic [AW-1:0] cfgAddr,
  input  logic [BW-1:0] cfgData,
  input  logic          measValid,
  output thr_strobe_t   strobe
);
  logic              pendValid;
  logic [SLOT_W-1:0] pendSlot;
  logic [BW-1:0]     pendByte;
  logic              inRange;
  logic              isLsb;
  logic [SLOT_W-1:0] wrSlot;

  assign inRange = cfgAddr < AW'(MAP_BYTES);
  assign isLsb   = cfgAddr[0];
  assign wrSlot  = cfgAddr[SLOT_W:1];

  // Upper byte parks here until its partner lower byte arrives (R3, R4)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendSlot  <= '0;
      pendByte  <= '0;
    end else if (cfgWrEn && inRange) begin
      if (!isLsb) begin
        pendValid <= 1'b1;
        pendSlot  <= wrSlot;
        pendByte  <= cfgData;
      end else begin
        pendValid <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe.sample = measValid;
    strobe.commit = cfgWrEn && inRange && isLsb && pendValid && (pendSlot == wrSlot);
    strobe.slot   = wrSlot;
    strobe.value  = {pendByte, cfgData};
  end

  // R3: a commit consumes the pending byte
  p_commit_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> !pendValid);

  // R4: out-of-range writes leave the pending state alone
  p_oob_keeps_pend_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !inRange) |=> ($stable(pendValid) && $stable(pendByte) && $stable(pendSlot)));
endmodule

// File: rtl/dmon_datapath.sv
module dmon_datapath
  import dmon_pkg::*;
#(
  parameter int             NQ          = QTY_N,
  parameter int             VW          = VAL_W,
  parameter logic [NQ-1:0]  SIGNED_MASK = NQ'(1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  thr_strobe_t       strobe,
  input  logic [NQ*VW-1:0]  measData,
  output logic [NQ*KIND_N-1:0] flags,
  output logic              anyAlarm
);
  localparam int NT = NQ * KIND_N;

  logic [NT-1:0][VW-1:0] thrQ;
  logic [NT-1:0]         flagQ;
  logic [NT-1:0]         flagNext;
  logic [NT-1:0]         alarmMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thrQ <= '0;
    end else if (strobe.commit) begin
      thrQ[strobe.slot] <= strobe.value;
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_qty
    logic [VW-1:0] reading;
    assign reading = measData[q*VW +: VW];
    for (genvar k = 0; k < KIND_N; k++) begin : g_kind
      logic [VW-1:0] lim;
      logic          above;
      logic          below;
      assign lim = thrQ[q*KIND_N + k];
      if (SIGNED_MASK[q]) begin : g_sgn
        assign above = $signed(reading) > $signed(lim);
        assign below = $signed(reading) < $signed(lim);
      end else begin : g_uns
        assign above = reading > lim;
        assign below = reading < lim;
      end
      // even kinds are high limits, odd kinds low limits
      if ((k % 2) == 0) begin : g_hi
        assign flagNext[q*KIND_N + k] = above;
      end else begin : g_lo
        assign flagNext[q*KIND_N + k] = below;
      end
      assign alarmMask[q*KIND_N + k] = (k < 2);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
    end else if (strobe.sample) begin
      flagQ <= flagNext;
    end
  end

  assign flags    = flagQ;
  assign anyAlarm = |(flagQ & alarmMask);

  // R3: limits move only on a commit strobe from the control
  p_thr_only_on_commit_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(thrQ));

  // R5: flags hold between samples
  p_flags_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.sample |=> $stable(flagQ));
endmodule

// File: rtl/dmon_thr_monitor.sv
module dmon_thr_monitor
  import dmon_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [BYTE_W-1:0] cfgData,
  input  logic              measValid,
  input  logic [MEAS_W-1:0] measData,
  output logic [THR_N-1:0]  flags,
  output logic              anyAlarm
);
  thr_strobe_t strobe;

  dmon_ctrl #(.AW(ADDR_W), .BW(BYTE_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgAddr   (cfgAddr),
    .cfgData   (cfgData),
    .measValid (measValid),
    .strobe    (strobe)
  );

  dmon_datapath #(.NQ(QTY_N), .VW(VAL_W), .SIGNED_MASK(QTY_N'(1))) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .measData (measData),
    .flags    (flags),
    .anyAlarm (anyAlarm)
  );

  // R9: the summary alarm can only rise right after a sample
  p_alarm_after_sample_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(anyAlarm) |-> $past(measValid));
endmodule

// File: tb/dmon_thr_monitor_tb.sv
module dmon_thr_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;

  // vectors: {rx, tx, bias, volt, temp}
  localparam logic [79:0] VEC [NV] = '{
    {16'h4000, 16'h4000, 16'h1000, 16'h8000, 16'h1900},
    {16'h4000, 16'h4000, 16'h1000, 16'h8000, 16'hF000},
    {16'h4000, 16'h4000, 16'h1000, 16'h8000, 16'h4800},
    {16'hC000, 16'h2000, 16'h0400, 16'h9000, 16'h5000},
    {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h7FFF},
    {16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h8000},
    {16'h0150, 16'h1800, 16'h0600, 16'h7001, 16'hF600}
  };

  logic        clk = 0;
  logic        rstN = 0;
  logic        cfgWrEn = 0;
  logic [7:0]  cfgAddr = 0;
  logic [7:0]  cfgData = 0;
  logic        measValid = 0;
  logic [79:0] measData = 0;
  logic [19:0] flags;
  logic        anyAlarm;

  int nChk = 0;
  int nFail = 0;
  logic [15:0] bthr [20];

  dmon_thr_monitor u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .measValid(measValid), .measData(measData),
    .flags(flags), .anyAlarm(anyAlarm)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [19:0] model(input logic [79:0] m);
    logic [19:0] f = '0;
    for (int q = 0; q < 5; q++) begin
      for (int k = 0; k < 4; k++) begin
        logic [15:0] v = m[q*16 +: 16];
        logic [15:0] t = bthr[q*4+k];
        logic gt, lt;
        if (q == 0) begin
          gt = $signed(v) > $signed(t);
          lt = $signed(v) < $signed(t);
        end else begin
          gt = v > t;
          lt = v < t;
        end
        f[q*4+k] = (k % 2 == 0) ? gt : lt;
      end
    end
    return f;
  endfunction

  function automatic logic alarmOf(input logic [19:0] f);
    logic a = 0;
    for (int q = 0; q < 5; q++) a = a | f[q*4] | f[q*4+1];
    return a;
  endfunction

  task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
    end
  endtask

  task automatic wrByte(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWrEn = 0;
  endtask

  task automatic wrPair(input int slot, input logic [15:0] v);
    wrByte(8'(slot*2), v[15:8]);
    wrByte(8'(slot*2+1), v[7:0]);
    bthr[slot] = v;
  endtask

  task automatic sample(input logic [79:0] m);
    @(negedge clk);
    measValid = 1; measData = m;
    @(negedge clk);
    measValid = 0;
  endtask

  task automatic sampleCheck(input string tag, input logic [79:0] m);
    logic [19:0] e;
    sample(m);
    e = model(m);
    check(tag, flags, e);
    check({tag, " alarm R9"}, {19'b0, anyAlarm}, {19'b0, alarmOf(e)});
  endtask

  localparam logic [15:0] LIMITS [20] = '{
    16'h5000, 16'hF600, 16'h4600, 16'h0000,
    16'h9000, 16'h7000, 16'h8C00, 16'h7400,
    16'h4000, 16'h0400, 16'h3000, 16'h0800,
    16'h8000, 16'h1000, 16'h6000, 16'h2000,
    16'hC000, 16'h0100, 16'hA000, 16'h0200
  };

  initial begin
    #(CLK_PERIOD*100000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    logic [19:0] held;
    for (int i = 0; i < 20; i++) bthr[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 reset flags", flags, 20'h0);
    check("R1 reset alarm", {19'b0, anyAlarm}, 20'h0);
    rstN = 1;
    @(negedge clk);
    // zero limits: every high flag set, no low flag
    sample({5{16'h0001}});
    check("R1 zero limits", flags, 20'h55555);

    for (int s = 0; s < 20; s++) wrPair(s, LIMITS[s]);

    // R2 R6 R7 R8 R9: table walk
    for (int i = 0; i < NV; i++) begin
      sampleCheck($sformatf("R6 R7 R8 vector %0d", i), VEC[i]);
    end
    // vector 2 is warning-only: summary must stay low
    sample(VEC[2]);
    check("R9 warning only", {19'b0, anyAlarm}, 20'h0);
    // vector 1: negative temperature sets temp low flags only
    sample(VEC[1]);
    check("R7 signed temp", flags & 20'h0000F, 20'h0000A);

    // R5: hold while strobe low
    held = flags;
    @(negedge clk);
    measData = VEC[4];
    repeat (3) @(negedge clk);
    check("R5 hold", flags, held);

    // R3: upper byte alone does not change the limit
    wrByte(8'd0, 8'h10);
    sampleCheck("R3 pending only", {16'h4000, 16'h4000, 16'h1000, 16'h8000, 16'h1800});
    wrByte(8'd1, 8'h00);
    bthr[0] = 16'h1000;
    sampleCheck("R3 committed", {16'h4000, 16'h4000, 16'h1000, 16'h8000, 16'h1800});

    // R4: wrong-slot lower byte, then lower byte with nothing pending
    wrByte(8'd2, 8'h00);
    wrByte(8'd5, 8'h55);
    wrByte(8'd3, 8'h00);
    sampleCheck("R4 mismatch ignored", {16'h4000, 16'h4000, 16'h1000, 16'h8000, 16'hF700});
    // R4: out-of-range writes between a pair
    wrByte(8'd0, 8'h7F);
    wrByte(8'd40, 8'h01);
    wrByte(8'd41, 8'h02);
    wrByte(8'd255, 8'h03);
    wrByte(8'd1, 8'hFF);
    bthr[0] = 16'h7FFF;
    sampleCheck("R4 oob ignored", {16'h4000, 16'h4000, 16'h1000, 16'h8000, 16'h7000});

    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule